// File: doc/BRIEF.md
# Pulse-Pause Frame Transmitter

This block drives the carrier-enable line of a reader that talks to a contactless tag. A command frame of up to `MAX_BITS` bits goes out least significant bit first. Every bit opens with a fixed stretch of carrier-off. The carrier then comes back on, and the time until the next pause tells the tag which value was sent: a long total period stands for 1 and a short one for 0. After the last bit, one more pause closes the frame and the carrier stays on. Time is counted in ticks, and one tick is `CLK_DIV` system clocks.

An outside keystream generator can whiten each bit. The block samples the keystream bit, XORs it into the data bit when whitening is requested, and strobes the generator so that it moves one step for every bit sent. Before a session, a charge request holds the carrier on for a power-up interval. After every frame a tick counter restarts, so the wait for the tag's reply is measured from the end of the frame.

Requests arrive on a valid/ready port. A request is taken in a cycle where `s_valid` and `s_ready` are both high. `s_ready` is low while a frame or a charge interval is in progress. The block keeps no copy of a `s_valid` that came while `s_ready` was low, so a source that drops `s_valid` before `s_ready` returns has made no request.

Top module: `ppe_frame_tx`

## Requirements
- R1: While reset is asserted, `carrier_on`, `frame_done` and `ks_adv` are 0, `gap_ticks` is 0 and `s_ready` is 1.
- R2: A request is taken on a clock edge where `s_valid` and `s_ready` are both 1. `s_ready` stays 0 from that edge up to, but not including, the cycle in which `frame_done` is high. A `s_valid` pulse while `s_ready` is 0 starts nothing, either then or later.
- R3: Each bit starts with `carrier_on` at 0 for `PAUSE_TICKS`×`CLK_DIV` cycles. The first bit's pause begins in the cycle right after the accepting edge.
- R4: The total period of a bit, counted from the start of its pause, is `ONE_TICKS`×`CLK_DIV` cycles for a transmitted 1 and `ZERO_TICKS`×`CLK_DIV` cycles for a transmitted 0. The next pause follows at once.
- R5: Data bits go out in order from bit 0 upward.
- R6: The transmitted value is the data bit XOR (`s_whiten` AND `ks_bit`). `ks_bit` is sampled in the cycle before the bit's pause begins. `ks_adv` is high for one cycle, in the first cycle of each bit, once per bit sent, whether or not whitening is on.
- R7: After the last bit, `carrier_on` is 0 for `PAUSE_TICKS`×`CLK_DIV` cycles and then stays 1. `frame_done` is high for exactly the first cycle in which the carrier is back on.
- R8: A bit count of 0 sends only the closing pause. A bit count above `MAX_BITS` is treated as `MAX_BITS`.
- R9: A `charge_req` while idle turns `carrier_on` to 1 for `CHARGE_TICKS`×`CLK_DIV` cycles. During that time `s_ready` is 0 and no `frame_done` occurs. Afterwards the block is idle with the carrier on. In a cycle where `charge_req` is high, `s_ready` is 0, so a charge has priority over a frame request.
- R10: `gap_ticks` is 0 in the `frame_done` cycle. It then rises by one every `CLK_DIV` cycles and holds at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Frame request valid |
| s_ready | output | 1 | Block idle and able to take a request |
| s_data | input | MAX_BITS | Frame data, bit 0 sent first |
| s_nbits | input | clog2(MAX_BITS+1) | Number of bits to send |
| s_whiten | input | 1 | XOR the keystream into this frame |
| charge_req | input | 1 | Start the power-up carrier interval |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | Step the keystream by one |
| carrier_on | output | 1 | Carrier enable |
| frame_done | output | 1 | One-cycle pulse when the closing pause ends |
| gap_ticks | output | GAP_W | Ticks since the last frame end, saturating |

## Verification
Cycle 0 is the first cycle after the accepting edge, and every delay is counted from there. The carrier drops in cycle 0. Each phase boundary falls on a multiple of `CLK_DIV` cycles. `frame_done` arrives in the cycle whose index equals the sum of the bit periods plus one pause, all in clocks. `ks_adv` comes in cycle 0 of each bit, and `gap_ticks` reaches 1 in cycle `CLK_DIV` after `frame_done`. The bench samples every output on the falling clock edge and records the carrier cycle by cycle until `frame_done`. It then compares that record with a waveform it builds from the data, the count and its own copy of the keystream. The done index is checked against a hand-computed length in ticks.

// File: rtl/ppe_tx_pkg.sv
package ppe_tx_pkg;

  // Phase of the line controller.
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_CHARGE = 3'd1,
    PH_PAUSE  = 3'd2,
    PH_MARK   = 3'd3,
    PH_EOF    = 3'd4
  } ph_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/ppe_tick_gen.sv
module ppe_tick_gen #(
  parameter int unsigned DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (restart || cnt_q == LAST)  cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  generate
    if (DIV > 1) begin : g_spacing
      // Two ticks never come back to back when a tick spans several clocks.
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3
    end
  endgenerate

endmodule

// File: rtl/ppe_bit_shifter.sv
module ppe_bit_shifter #(
  parameter int unsigned MAX_BITS = 32,
  parameter int unsigned NB_W     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] load_data,
  input  logic [NB_W-1:0]     load_nbits,
  input  logic                load_whiten,
  input  logic                step,
  input  logic                ks_bit,
  output logic                cur_bit,
  output logic                last_bit,
  output logic                empty,
  output logic                ks_adv
);
  localparam logic [NB_W-1:0] NB_MAX = NB_W'(MAX_BITS);

  logic [MAX_BITS-1:0] sh_q;
  logic [NB_W-1:0]     left_q;
  logic [NB_W-1:0]     nclamp;
  logic                wh_q, cur_q, adv_q;

  assign nclamp = (load_nbits > NB_MAX) ? NB_MAX : load_nbits;
  assign empty  = (load_nbits == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      wh_q   <= 1'b0;
      cur_q  <= 1'b0;
      adv_q  <= 1'b0;
    end else if (load) begin
      wh_q <= load_whiten;
      if (!empty) begin
        cur_q  <= load_data[0] ^ (load_whiten & ks_bit);
        sh_q   <= load_data >> 1;
        left_q <= nclamp - 1'b1;
        adv_q  <= 1'b1;
      end else begin
        adv_q  <= 1'b0;
      end
    end else if (step) begin
      cur_q  <= sh_q[0] ^ (wh_q & ks_bit);
      sh_q   <= sh_q >> 1;
      left_q <= left_q - 1'b1;
      adv_q  <= 1'b1;
    end else begin
      adv_q  <= 1'b0;
    end
  end

  assign cur_bit  = cur_q;
  assign last_bit = (left_q == '0);
  assign ks_adv   = adv_q;

  // The keystream strobe is a single-cycle pulse per bit.
  AST_KS_ADV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ks_adv |=> !ks_adv); // R6
  // A new frame is never loaded while the controller is stepping bits.
  AST_NO_LOAD_IN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && step)); // R2

endmodule

// File: rtl/ppe_phase_ctrl.sv
module ppe_phase_ctrl
  import ppe_tx_pkg::*;
#(
  parameter int unsigned CLK_DIV      = 32,
  parameter int unsigned PAUSE_TICKS  = 30,
  parameter int unsigned ONE_TICKS    = 150,
  parameter int unsigned ZERO_TICKS   = 90,
  parameter int unsigned CHARGE_TICKS = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic s_valid,
  input  logic charge_req,
  input  logic empty,
  input  logic cur_bit,
  input  logic last_bit,
  output logic s_ready,
  output logic accept,
  output logic charge_go,
  output logic step,
  output logic frame_end,
  output logic carrier,
  output logic done
);
  localparam int unsigned TOP = max4(PAUSE_TICKS, ONE_TICKS, ZERO_TICKS, CHARGE_TICKS);
  localparam int unsigned TW  = $clog2(TOP + 1);
  localparam logic [TW-1:0] P_LAST   = TW'(PAUSE_TICKS - 1);
  localparam logic [TW-1:0] ONE_LAST = TW'(ONE_TICKS - 1);
  localparam logic [TW-1:0] ZER_LAST = TW'(ZERO_TICKS - 1);
  localparam logic [TW-1:0] CHG_LAST = TW'(CHARGE_TICKS - 1);
  localparam logic [31:0]   PAUSE_CYC = 32'(PAUSE_TICKS * CLK_DIV);

  ph_e           ph_q;
  logic [TW-1:0] tcnt_q;
  logic [TW-1:0] mark_last;
  logic          carrier_q, done_q;
  logic          pause_end, mark_end, eof_end, charge_end;

  assign s_ready   = (ph_q == PH_IDLE) && !charge_req;
  assign accept    = s_valid && s_ready;
  assign charge_go = (ph_q == PH_IDLE) && charge_req;

  // The tick counter runs from the start of the pause, so the mark ends
  // when the whole bit period has elapsed.
  assign mark_last  = cur_bit ? ONE_LAST : ZER_LAST;
  assign pause_end  = (ph_q == PH_PAUSE)  && tick && (tcnt_q == P_LAST);
  assign mark_end   = (ph_q == PH_MARK)   && tick && (tcnt_q == mark_last);
  assign eof_end    = (ph_q == PH_EOF)    && tick && (tcnt_q == P_LAST);
  assign charge_end = (ph_q == PH_CHARGE) && tick && (tcnt_q == CHG_LAST);

  assign step      = mark_end && !last_bit;
  assign frame_end = eof_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      tcnt_q    <= '0;
      carrier_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= eof_end;
      unique case (ph_q)
        PH_IDLE: begin
          if (charge_go) begin
            ph_q      <= PH_CHARGE;
            carrier_q <= 1'b1;
            tcnt_q    <= '0;
          end else if (accept) begin
            ph_q      <= empty ? PH_EOF : PH_PAUSE;
            carrier_q <= 1'b0;
            tcnt_q    <= '0;
          end
        end
        PH_CHARGE: begin
          if (charge_end) begin
            ph_q   <= PH_IDLE;
            tcnt_q <= '0;
          end else if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        PH_PAUSE: begin
          if (tick) tcnt_q <= tcnt_q + 1'b1;
          if (pause_end) begin
            ph_q      <= PH_MARK;
            carrier_q <= 1'b1;
          end
        end
        PH_MARK: begin
          if (mark_end) begin
            ph_q      <= last_bit ? PH_EOF : PH_PAUSE;
            carrier_q <= 1'b0;
            tcnt_q    <= '0;
          end else if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        PH_EOF: begin
          if (eof_end) begin
            ph_q      <= PH_IDLE;
            carrier_q <= 1'b1;
            tcnt_q    <= '0;
          end else if (tick) begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign carrier = carrier_q;
  assign done    = done_q;

  // Length of the current carrier-off run while busy, for the pause check.
  logic [31:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                low_run_q <= '0;
    else if (!carrier_q && ph_q != PH_IDLE)    low_run_q <= low_run_q + 1'b1;
    else                                       low_run_q <= '0;
  end

  AST_PAUSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(carrier_q) && ph_q != PH_CHARGE) |-> (low_run_q == PAUSE_CYC)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_CARRIER_ON: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> carrier); // R7
  AST_IDLE_CARRIER_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && $past(ph_q) == PH_IDLE) |-> $stable(carrier_q)); // R7
  AST_BIT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_MARK && $past(ph_q) == PH_MARK) |-> $stable(cur_bit)); // R4

endmodule

// File: rtl/ppe_gap_timer.sv
module ppe_gap_timer #(
  parameter int unsigned GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  output logic [GAP_W-1:0] gap
);
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          gap_q <= '0;
    else if (clr)                        gap_q <= '0;
    else if (tick && gap_q != GAP_MAX)   gap_q <= gap_q + 1'b1;
  end

  assign gap = gap_q;

  AST_GAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (gap == '0)); // R10
  AST_GAP_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (gap == GAP_MAX && !clr) |=> (gap == GAP_MAX)); // R10

endmodule

// File: rtl/ppe_frame_tx.sv
module ppe_frame_tx
  import ppe_tx_pkg::*;
#(
  parameter int unsigned CLK_DIV      = 32,
  parameter int unsigned PAUSE_TICKS  = 30,
  parameter int unsigned ONE_TICKS    = 150,
  parameter int unsigned ZERO_TICKS   = 90,
  parameter int unsigned CHARGE_TICKS = 1500,
  parameter int unsigned MAX_BITS     = 32,
  parameter int unsigned GAP_W        = 16,
  localparam int unsigned NB_W        = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [MAX_BITS-1:0] s_data,
  input  logic [NB_W-1:0]     s_nbits,
  input  logic                s_whiten,
  input  logic                charge_req,
  input  logic                ks_bit,
  output logic                ks_adv,
  output logic                carrier_on,
  output logic                frame_done,
  output logic [GAP_W-1:0]    gap_ticks
);
  logic tick, restart;
  logic accept, charge_go, step, frame_end;
  logic cur_bit, last_bit, empty;

  // The tick phase is realigned whenever a timed interval begins.
  assign restart = accept || charge_go || frame_end;

  ppe_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (tick)
  );

  ppe_bit_shifter #(.MAX_BITS(MAX_BITS), .NB_W(NB_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .load_data   (s_data),
    .load_nbits  (s_nbits),
    .load_whiten (s_whiten),
    .step        (step),
    .ks_bit      (ks_bit),
    .cur_bit     (cur_bit),
    .last_bit    (last_bit),
    .empty       (empty),
    .ks_adv      (ks_adv)
  );

  ppe_phase_ctrl #(
    .CLK_DIV      (CLK_DIV),
    .PAUSE_TICKS  (PAUSE_TICKS),
    .ONE_TICKS    (ONE_TICKS),
    .ZERO_TICKS   (ZERO_TICKS),
    .CHARGE_TICKS (CHARGE_TICKS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .s_valid    (s_valid),
    .charge_req (charge_req),
    .empty      (empty),
    .cur_bit    (cur_bit),
    .last_bit   (last_bit),
    .s_ready    (s_ready),
    .accept     (accept),
    .charge_go  (charge_go),
    .step       (step),
    .frame_end  (frame_end),
    .carrier    (carrier_on),
    .done       (frame_done)
  );

  ppe_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (frame_end),
    .tick  (tick),
    .gap   (gap_ticks)
  );

endmodule

// File: tb/sim_ppe_frame_tx.sv
`timescale 1ns/1ps
module sim_ppe_frame_tx;
  localparam int DIV = 2, PT = 3, OT = 9, ZT = 6, CT = 5, GW = 8, MB = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          s_valid = 1'b0, s_whiten = 1'b0, charge_req = 1'b0;
  logic [31:0]   s_data = '0;
  logic [5:0]    s_nbits = '0;
  logic          s_ready, ks_bit, ks_adv, carrier_on, frame_done;
  logic [GW-1:0] gap_ticks;

  ppe_frame_tx #(.CLK_DIV(DIV), .PAUSE_TICKS(PT), .ONE_TICKS(OT), .ZERO_TICKS(ZT),
                 .CHARGE_TICKS(CT), .MAX_BITS(MB), .GAP_W(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_nbits(s_nbits), .s_whiten(s_whiten), .charge_req(charge_req), .ks_bit(ks_bit),
    .ks_adv(ks_adv), .carrier_on(carrier_on), .frame_done(frame_done), .gap_ticks(gap_ticks));

  int n_checks = 0, n_err = 0;
  logic [15:0] tb_ks;
  int adv_cnt;
  logic act_c [0:1023];
  logic exp_c [0:1023];

  function automatic logic [15:0] ks_next(input logic [15:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
  endfunction

  // Bench-owned keystream source, stepped by the block's strobe.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_ks   <= 16'hACE1;
      adv_cnt <= 0;
    end else if (ks_adv) begin
      tb_ks   <= ks_next(tb_ks);
      adv_cnt <= adv_cnt + 1;
    end
  end
  assign ks_bit = tb_ks[0];

  task automatic check(input bit ok, input string msg);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s", msg);
    end
  endtask

  // Sends one frame from idle; returns at the falling edge of the done cycle.
  task automatic run_frame(input logic [31:0] d, input logic [5:0] n, input logic wh,
                           input int exp_len, input int poke_at, input string tag);
    int nn, len, done_at, adv0, ready_bad, mism, pos;
    logic [15:0] ks;
    logic b;
    nn = (n > 6'd32) ? 32 : int'(n);
    ks = tb_ks;
    pos = 0;
    for (int i = 0; i < nn; i++) begin
      b  = d[i] ^ (wh & ks[0]);
      ks = ks_next(ks);
      for (int c = 0; c < (b ? OT : ZT) * DIV; c++) begin
        exp_c[pos] = (c >= PT * DIV);
        pos++;
      end
    end
    for (int c = 0; c < PT * DIV; c++) begin
      exp_c[pos] = 1'b0;
      pos++;
    end
    len = pos;
    adv0 = adv_cnt;
    s_data = d; s_nbits = n; s_whiten = wh; s_valid = 1'b1;
    @(posedge clk);
    done_at = -1; ready_bad = 0; mism = 0;
    for (int cyc = 0; cyc < 1000; cyc++) begin
      @(negedge clk);
      s_valid = (cyc == poke_at);
      if (cyc == poke_at) begin
        s_data = 32'hFFFF_FFFF; s_nbits = 6'd8;
      end
      if (frame_done) begin
        done_at = cyc;
        break;
      end
      act_c[cyc] = carrier_on;
      if (s_ready) ready_bad++;
    end
    if (done_at == len)
      for (int k = 0; k < len; k++) if (act_c[k] !== exp_c[k]) mism++;
    check(done_at == len, $sformatf("%s R7 done cycle actual=%0d expected=%0d", tag, done_at, len));
    check(done_at == len && mism == 0,
          $sformatf("%s R3 R4 carrier waveform bad cycles actual=%0d expected=0", tag, mism));
    check(carrier_on === 1'b1 && s_ready === 1'b1,
          $sformatf("%s R7 at done carrier/ready actual=%b%b expected=11", tag, carrier_on, s_ready));
    check(ready_bad == 0, $sformatf("%s R2 ready high while busy actual=%0d expected=0", tag, ready_bad));
    check(adv_cnt - adv0 == nn,
          $sformatf("%s R6 keystream steps actual=%0d expected=%0d", tag, adv_cnt - adv0, nn));
    if (exp_len >= 0)
      check(done_at == exp_len * DIV,
            $sformatf("%s R4 frame length actual=%0d expected=%0d", tag, done_at, exp_len * DIV));
  endtask

  // {data, bit count, expected frame length in ticks}, whitening off.
  localparam logic [47:0] VEC [6] = '{
    {32'h0000_0055, 6'd7,  10'd57},
    {32'h0000_0019, 6'd6,  10'd48},
    {32'hFFFF_FFFF, 6'd32, 10'd291},
    {32'h0000_0000, 6'd11, 10'd69},
    {32'h0000_00A5, 6'd0,  10'd3},
    {32'h0000_0001, 6'd40, 10'd198}
  };
  localparam string VTAG [6] = '{"R5 alt", "R5 mixed", "R4 ones", "R4 zeros",
                                 "R8 empty", "R8 clamp"};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin : main
    int rise_at;
    bit carrier_dropped, done_seen;
    // R1 reset state
    #12;
    check(carrier_on === 1'b0 && frame_done === 1'b0,
          $sformatf("R1 carrier/done actual=%b%b expected=00", carrier_on, frame_done));
    check(s_ready === 1'b1 && ks_adv === 1'b0,
          $sformatf("R1 ready/adv actual=%b%b expected=10", s_ready, ks_adv));
    check(gap_ticks === '0, $sformatf("R1 gap actual=%0d expected=0", gap_ticks));
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 charge with a competing frame request in the same cycle
    charge_req = 1'b1; s_valid = 1'b1; s_data = 32'h1; s_nbits = 6'd1;
    #0.1;
    check(s_ready === 1'b0, $sformatf("R9 ready during charge request actual=%b expected=0", s_ready));
    @(posedge clk);
    rise_at = -1; carrier_dropped = 0; done_seen = 0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk);
      charge_req = 1'b0; s_valid = 1'b0;
      if (!carrier_on) carrier_dropped = 1;
      if (frame_done) done_seen = 1;
      if (s_ready && rise_at < 0) rise_at = cyc;
    end
    check(rise_at == CT * DIV, $sformatf("R9 charge length actual=%0d expected=%0d", rise_at, CT * DIV));
    check(!carrier_dropped && !done_seen,
          $sformatf("R9 carrier stays on, no done actual=%b%b expected=00", carrier_dropped, done_seen));

    // Table of unwhitened frames
    for (int i = 0; i < 6; i++)
      run_frame(VEC[i][47:16], VEC[i][15:10], 1'b0, int'(VEC[i][9:0]), -1, VTAG[i]);

    // R6 whitened frames against the bench keystream
    run_frame(32'h0000_0055, 6'd7, 1'b1, -1, -1, "R6 whiten a");
    run_frame(32'h0000_0000, 6'd16, 1'b1, -1, -1, "R6 whiten b");

    // R2 request while busy is dropped
    run_frame(32'h0000_000F, 6'd4, 1'b0, -1, 5, "R2 poke");
    done_seen = 0; carrier_dropped = 0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      if (frame_done) done_seen = 1;
      if (!carrier_on) carrier_dropped = 1;
    end
    check(!done_seen && !carrier_dropped,
          $sformatf("R2 ignored request started a frame actual=%b%b expected=00", done_seen, carrier_dropped));

    // R10 gap timer after a frame
    run_frame(32'h0000_0003, 6'd2, 1'b0, -1, -1, "R10 gap");
    check(gap_ticks == 0, $sformatf("R10 gap at done actual=%0d expected=0", gap_ticks));
    repeat (2) @(negedge clk);
    check(gap_ticks == 1, $sformatf("R10 gap one tick actual=%0d expected=1", gap_ticks));
    @(negedge clk);
    check(gap_ticks == 1, $sformatf("R10 gap mid tick actual=%0d expected=1", gap_ticks));
    @(negedge clk);
    check(gap_ticks == 2, $sformatf("R10 gap two ticks actual=%0d expected=2", gap_ticks));
    repeat (600) @(negedge clk);
    check(gap_ticks == 255, $sformatf("R10 gap saturation actual=%0d expected=255", gap_ticks));

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule